// File: doc/BRIEF.md
# Index-Set Trigger Semaphore with Periodic Poller

This block keeps a 32-bit trigger semaphore. Software raises one trigger at a time by writing the number of that trigger to an index port. Hardware then sets the one matching bit, so software never has to read, modify and write the register back. Several requests for the same trigger made between polls merge into one.

On the acquisition side, an internal interval counter reads the semaphore once every `POLL_PERIOD` clock cycles. The value it reads is cleared from the register in the same cycle, and every bit of that value drives a one-cycle pulse on the trigger output vector in the following cycle. Bit i of the semaphore drives `trig_o[i]`, which is external trigger number i+1.

An index write that arrives in the same cycle as the clearing read is not lost. Its bit stays set and is returned by the next poll. The default period is 5000 cycles, which is 50 µs at a 100 MHz clock.

Top module: `trig_sem_poller`

## Requirements
- R1: While `rst` is high at a rising edge, the semaphore and `trig_o` are cleared and the interval counter restarts. The first `poll_o` is high in the `POLL_PERIOD`-th cycle after reset is released, counting the first cycle after release as cycle 1.
- R2: A write with `wr_en` high and `wr_idx` = i, where 0 <= i <= 31, sets semaphore bit i only. That bit later fires `trig_o[i]`, which is trigger number i+1. Indices 0 and 31 are the bounds.
- R3: A write with `wr_idx` of 32 or above changes no bit, and no trigger results from it.
- R4: `poll_o` is high for exactly one cycle in every `POLL_PERIOD` cycles.
- R5: A poll clears every bit it reads, so a poll that is not preceded by any new write returns no triggers.
- R6: In the cycle after a poll, `trig_o` equals the semaphore value read by that poll. At all other times `trig_o` is zero, so each trigger is a single-cycle pulse.
- R7: A valid index write in the poll cycle itself is not part of that poll's triggers. Its bit stays set and fires at the next poll.
- R8: Writing an index whose bit is already set has no further effect. Any number of requests for the same trigger between two polls give one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Index write strobe from the processor side |
| wr_idx | input | IDX_W (8) | Trigger index to set; values of 32 or more are ignored |
| poll_o | output | 1 | High in the cycle in which the semaphore is read and cleared |
| trig_o | output | NUM_TRIG (32) | One-cycle trigger pulses; bit i is trigger number i+1 |

## Verification
A write is sampled at a rising edge, and its bit is set one edge later. `poll_o` is a decode of the counter register, so it is valid during the poll cycle itself. The pulses on `trig_o` appear after the edge that ends the poll cycle and last one cycle. The bench drives inputs on falling edges. On every falling edge it compares `poll_o` and `trig_o` against a behavioural model that is updated on the rising edge. The directed checks read `trig_o` exactly one falling edge after the falling edge where `poll_o` is seen high. The same-cycle case is produced by asserting a write on the falling edge of a poll cycle.

// File: rtl/trig_sem_pkg.sv
package trig_sem_pkg;
    localparam int unsigned DEF_NUM_TRIG    = 32;
    localparam int unsigned DEF_IDX_W       = 8;
    localparam int unsigned DEF_POLL_PERIOD = 5000;
endpackage

// File: rtl/tsp_poll_timer.sv
module tsp_poll_timer #(
    parameter int unsigned POLL_PERIOD = trig_sem_pkg::DEF_POLL_PERIOD
) (
    input  logic clk,
    input  logic rst,
    output logic poll_o
);
    localparam int unsigned CNT_W = (POLL_PERIOD > 2) ? $clog2(POLL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign poll_o = (st_q.cnt == LAST);
endmodule

// File: rtl/tsp_index_decode.sv
module tsp_index_decode #(
    parameter int unsigned NUM_TRIG = trig_sem_pkg::DEF_NUM_TRIG,
    parameter int unsigned IDX_W    = trig_sem_pkg::DEF_IDX_W
) (
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic [NUM_TRIG-1:0] set_mask
);
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_dec
        assign set_mask[i] = wr_en && (wr_idx == IDX_W'(i));
    end
endmodule

// File: rtl/tsp_sem_bits.sv
module tsp_sem_bits #(
    parameter int unsigned NUM_TRIG = trig_sem_pkg::DEF_NUM_TRIG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                poll,
    input  logic [NUM_TRIG-1:0] set_mask,
    output logic [NUM_TRIG-1:0] read_val,
    output logic [NUM_TRIG-1:0] sem_o
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] bits;
    } sem_t;

    sem_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        read_val = poll ? st_q.bits : '0;
        st_d.bits = (st_q.bits & ~read_val) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sem_o = st_q.bits;
endmodule

// File: rtl/tsp_trig_out.sv
module tsp_trig_out #(
    parameter int unsigned NUM_TRIG = trig_sem_pkg::DEF_NUM_TRIG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] read_val,
    output logic [NUM_TRIG-1:0] trig_o
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] pulse;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = read_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.pulse;
endmodule

// File: rtl/trig_sem_poller.sv
module trig_sem_poller #(
    parameter int unsigned NUM_TRIG    = trig_sem_pkg::DEF_NUM_TRIG,
    parameter int unsigned IDX_W       = trig_sem_pkg::DEF_IDX_W,
    parameter int unsigned POLL_PERIOD = trig_sem_pkg::DEF_POLL_PERIOD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic                poll_o,
    output logic [NUM_TRIG-1:0] trig_o
);
    logic [NUM_TRIG-1:0] set_mask;
    logic [NUM_TRIG-1:0] read_val;
    logic [NUM_TRIG-1:0] sem_bits;

    tsp_poll_timer #(.POLL_PERIOD(POLL_PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .poll_o (poll_o)
    );

    tsp_index_decode #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_dec (
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .set_mask (set_mask)
    );

    tsp_sem_bits #(.NUM_TRIG(NUM_TRIG)) u_sem (
        .clk      (clk),
        .rst      (rst),
        .poll     (poll_o),
        .set_mask (set_mask),
        .read_val (read_val),
        .sem_o    (sem_bits)
    );

    tsp_trig_out #(.NUM_TRIG(NUM_TRIG)) u_out (
        .clk      (clk),
        .rst      (rst),
        .read_val (read_val),
        .trig_o   (trig_o)
    );
endmodule

// File: rtl/trig_sem_poller_chk.sv
module trig_sem_poller_chk #(
    parameter int unsigned NUM_TRIG = 32,
    parameter int unsigned IDX_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_idx,
    input logic                poll_o,
    input logic [NUM_TRIG-1:0] trig_o,
    input logic [NUM_TRIG-1:0] sem_bits
);
    logic [NUM_TRIG-1:0] idx_mask;
    logic                idx_ok;

    always_comb begin
        idx_mask = '0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (int'(wr_idx) == i) idx_mask[i] = 1'b1;
        end
        idx_ok = (int'(wr_idx) < NUM_TRIG);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (trig_o == '0 && sem_bits == '0));

    p_sets_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx_ok) |=> ((sem_bits & $past(idx_mask)) != '0));

    p_ignore_big_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idx_ok && !poll_o) |=> (sem_bits == $past(sem_bits)));

    p_poll_single_r4: assert property (@(posedge clk) disable iff (rst)
        poll_o |=> !poll_o);

    p_trig_match_r6: assert property (@(posedge clk) disable iff (rst)
        poll_o |=> (trig_o == $past(sem_bits)));

    p_trig_only_after_poll_r6: assert property (@(posedge clk) disable iff (rst)
        (trig_o != '0) |-> $past(poll_o));

    p_same_cycle_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (poll_o && wr_en && idx_ok) |=> ((sem_bits & $past(idx_mask)) != '0));

    p_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        (poll_o && !wr_en) |=> (sem_bits == '0));
endmodule

bind trig_sem_poller trig_sem_poller_chk #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .poll_o   (poll_o),
    .trig_o   (trig_o),
    .sem_bits (sem_bits)
);

// File: tb/test_trig_sem_poller.sv
module test_trig_sem_poller;
    localparam int P = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = 8'd0;
    logic        poll_o;
    logic [31:0] trig_o;

    int t_checks = 0, t_errors = 0;
    int m_checks = 0, m_errors = 0;

    int          m_cnt = 0;
    logic [31:0] m_sem = '0;
    logic [31:0] m_trig = '0;

    always #5 clk = ~clk;

    trig_sem_poller #(.NUM_TRIG(32), .IDX_W(8), .POLL_PERIOD(P)) i_trig_sem_poller (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .poll_o(poll_o), .trig_o(trig_o)
    );

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sem = '0; m_trig = '0;
        end else begin
            bit fire;
            fire = (m_cnt == P - 1);
            m_trig = fire ? m_sem : 32'h0;
            if (fire) m_sem = 32'h0;
            if (wr_en && wr_idx < 32) m_sem[wr_idx] = 1'b1;
            m_cnt = fire ? 0 : m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            m_checks++;
            if (poll_o !== (m_cnt == P - 1)) begin
                m_errors++;
                $display("FAIL R4 model poll_o act=%0b exp=%0b", poll_o, (m_cnt == P - 1));
            end
            m_checks++;
            if (trig_o !== m_trig) begin
                m_errors++;
                $display("FAIL R6 model trig_o act=%h exp=%h", trig_o, m_trig);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        t_checks++;
        if (act !== exp) begin
            t_errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int idx);
        wr_en = 1'b1; wr_idx = 8'(idx);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_poll();
        while (poll_o !== 1'b1) @(negedge clk);
    endtask

    task automatic poll_and_check(input string req, input logic [31:0] exp);
        wait_poll();
        @(negedge clk);
        chk(req, trig_o, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 trig after reset", trig_o, 32'h0);
        n = 0;
        while (poll_o !== 1'b1 && n < 10 * P) begin @(negedge clk); n++; end
        chk("R1 first poll distance", 32'(n), 32'(P - 1));
        @(negedge clk); n = 1;
        while (poll_o !== 1'b1 && n < 10 * P) begin @(negedge clk); n++; end
        chk("R4 poll spacing", 32'(n), 32'(P));
        @(negedge clk);

        do_write(5);
        poll_and_check("R2 single index 5", 32'h0000_0020);
        @(negedge clk);
        chk("R6 pulse is one cycle", trig_o, 32'h0);

        poll_and_check("R5 empty after clearing read", 32'h0);

        do_write(3); do_write(3); do_write(17); do_write(3);
        poll_and_check("R8 repeated writes merge", 32'h0002_0008);

        do_write(32); do_write(200); do_write(255);
        poll_and_check("R3 out-of-range ignored", 32'h0);

        do_write(0); do_write(31);
        poll_and_check("R2 bounds 0 and 31", 32'h8000_0001);

        wait_poll();
        do_write(9);
        chk("R7 same-cycle write not in this poll", trig_o, 32'h0);
        poll_and_check("R7 same-cycle write kept", 32'h0000_0200);

        do_write(12);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 trig cleared by reset", trig_o, 32'h0);
        poll_and_check("R1 semaphore cleared by reset", 32'h0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", t_checks + m_checks, t_errors + m_errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        t_errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", t_checks + m_checks + 1, t_errors + m_errors);
        $finish;
    end
endmodule